// File: doc/BRIEF.md
# Double-Buffered Segmented DAC Register Interface

This block is the synchronous digital front end of a 14-bit current-output converter. A processor on an 8-bit bus writes to it with an active-low select, an active-low write strobe and a two-bit address code. Two holding registers keep the upper and lower halves of a code. A transfer command then moves both halves at once into the converter register, so the analog output never shows a half-updated code. A direct address loads the converter register straight from the bus in one write. With all zeros or all ones on the bus, this sets zero or full scale in a single cycle.

The converter register drives the switch array of a segmented ladder. Its top three bits become seven equally weighted segment lines, and these are thermometer coded. Its eleven low bits drive the binary-weighted switches unchanged. The bus inputs are sampled on the system clock. A write takes effect on the first clock where select and strobe are both low, so each strobe makes exactly one update, however long it is held.

Top module: `dac_front`

## Requirements
- R1: While rst_n is low, the holding registers and the converter register are zero, so dac_code, seg_on and bin_on are all zero.
- R2: While cs_n is high, no register changes, whatever wr_n, addr and data do.
- R3: A write happens on the clock edge where cs_n and wr_n are both sampled low after they were not both low at the previous edge. Holding the strobe low for more cycles makes no further update, even if data changes.
- R4: addr = 2'b00 (direct): a write loads the low holding register with data[7:0] and the high holding register with data[5:0]. In the same edge it loads dac_code with {data[5:0], data[7:0]}.
- R5: addr = 2'b01: a write loads only the high holding register from data[5:0]. dac_code is unchanged.
- R6: addr = 2'b10: a write loads only the low holding register from data[7:0]. dac_code is unchanged.
- R7: addr = 2'b11 (transfer): a write copies {high, low} holding registers into dac_code in one edge. The bus data and both holding registers are unaffected.
- R8: seg_on is a thermometer code of dac_code[13:11]. A value k sets seg_on[k-1:0] and clears the rest, so 0 gives 7'h00 and 7 gives 7'h7F.
- R9: bin_on equals dac_code[10:0].
- R10: data[7:6] have no effect on a high-byte write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; bus inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | Address code: 00 direct, 01 high byte, 10 low byte, 11 transfer |
| data | input | 8 | Bus data, right-justified |
| dac_code | output | 14 | Converter register contents |
| seg_on | output | 7 | Thermometer-coded segment switch lines |
| bin_on | output | 11 | Binary-weighted switch lines |

## Verification
The bench builds the block with its default widths: an 8-bit bus, 14-bit resolution and a 3-bit segmented top. With these widths a direct load of k shifted left by three reaches every one of the eight segment codes. Full scale and zero each come from a single write. The unused upper bits of the high byte can be set to ones to show they are dropped. Random writes with random hold lengths and deselected cycles then mix all four address codes. This exercises both orders of loading the two bytes before a transfer.

// File: rtl/dac_if_pkg.sv
package dac_if_pkg;
  typedef enum logic [1:0] {
    ADR_DIRECT = 2'b00,
    ADR_HIGH   = 2'b01,
    ADR_LOW    = 2'b10,
    ADR_XFER   = 2'b11
  } addr_code_e;
endpackage

// File: rtl/wr_strobe_sync.sv
// Turns the sampled select and strobe pair into a one-cycle write pulse.
module wr_strobe_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic wr_n,
  output logic wr_fire
);
  logic act_now;
  logic act_q;
  logic act_d;

  always_comb begin
    act_now = ~cs_n & ~wr_n;
    act_d   = act_now;
    wr_fire = act_now & ~act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act_d;
  end
endmodule

// File: rtl/dac_buffer.sv
// Holding registers plus the converter register, steered by the address code.
module dac_buffer
  import dac_if_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int RES_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_fire,
  input  logic [1:0]       addr,
  input  logic [BUS_W-1:0] data,
  output logic [RES_W-1:0] dac_q
);
  localparam int HI_W = RES_W - BUS_W;

  addr_code_e          code;
  logic [HI_W-1:0]     hi_q, hi_d;
  logic [BUS_W-1:0]    lo_q, lo_d;
  logic [RES_W-1:0]    dac_d;
  logic                hi_en, lo_en, dac_en;

  always_comb begin
    code   = addr_code_e'(addr);
    hi_en  = 1'b0;
    lo_en  = 1'b0;
    dac_en = 1'b0;
    hi_d   = data[HI_W-1:0];
    lo_d   = data;
    dac_d  = {hi_q, lo_q};
    if (wr_fire) begin
      unique case (code)
        ADR_DIRECT: begin
          hi_en  = 1'b1;
          lo_en  = 1'b1;
          dac_en = 1'b1;
          dac_d  = {data[HI_W-1:0], data};
        end
        ADR_HIGH: hi_en  = 1'b1;
        ADR_LOW:  lo_en  = 1'b1;
        ADR_XFER: dac_en = 1'b1;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      lo_q  <= '0;
      dac_q <= '0;
    end else begin
      if (hi_en)  hi_q  <= hi_d;
      if (lo_en)  lo_q  <= lo_d;
      if (dac_en) dac_q <= dac_d;
    end
  end
endmodule

// File: rtl/seg_decoder.sv
// Thermometer decoder for the segmented top bits.
module seg_decoder #(
  parameter int SEG_BITS = 3
) (
  input  logic [SEG_BITS-1:0]      code_i,
  output logic [(2**SEG_BITS)-2:0] therm_o
);
  localparam int SEG_N = (2**SEG_BITS) - 1;

  for (genvar i = 0; i < SEG_N; i++) begin : g_seg
    assign therm_o[i] = (code_i > SEG_BITS'(i));
  end
endmodule

// File: rtl/dac_front.sv
module dac_front
  import dac_if_pkg::*;
#(
  parameter int BUS_W    = 8,
  parameter int RES_W    = 14,
  parameter int SEG_BITS = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cs_n,
  input  logic                          wr_n,
  input  logic [1:0]                    addr,
  input  logic [BUS_W-1:0]              data,
  output logic [RES_W-1:0]              dac_code,
  output logic [(2**SEG_BITS)-2:0]      seg_on,
  output logic [RES_W-SEG_BITS-1:0]     bin_on
);
  localparam int BIN_W = RES_W - SEG_BITS;

  logic wr_fire;

  wr_strobe_sync u_strobe (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .wr_n    (wr_n),
    .wr_fire (wr_fire)
  );

  dac_buffer #(.BUS_W(BUS_W), .RES_W(RES_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_fire (wr_fire),
    .addr    (addr),
    .data    (data),
    .dac_q   (dac_code)
  );

  seg_decoder #(.SEG_BITS(SEG_BITS)) u_seg (
    .code_i  (dac_code[RES_W-1:BIN_W]),
    .therm_o (seg_on)
  );

  assign bin_on = dac_code[BIN_W-1:0];
endmodule

// File: rtl/dac_front_chk.sv
module dac_front_chk #(
  parameter int BUS_W    = 8,
  parameter int RES_W    = 14,
  parameter int SEG_BITS = 3
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      cs_n,
  input logic                      wr_n,
  input logic [1:0]                addr,
  input logic [BUS_W-1:0]          data,
  input logic [RES_W-1:0]          dac_code,
  input logic [(2**SEG_BITS)-2:0]  seg_on,
  input logic [RES_W-SEG_BITS-1:0] bin_on
);
  localparam int HI_W  = RES_W - BUS_W;
  localparam int BIN_W = RES_W - SEG_BITS;

  logic strb_q;
  logic strb_now;
  logic fire;

  assign strb_now = ~cs_n & ~wr_n;
  assign fire     = strb_now & ~strb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strb_q <= 1'b0;
    else        strb_q <= strb_now;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (dac_code == '0 && seg_on == '0 && bin_on == '0));

  assert_deselect_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> $stable(dac_code));

  assert_single_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_now && strb_q) |=> $stable(dac_code));

  assert_direct_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && addr == 2'b00) |=> dac_code == {$past(data[HI_W-1:0]), $past(data)});

  // covers R5 and R6: byte writes leave the converter register alone
  assert_byte_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (addr == 2'b01 || addr == 2'b10)) |=> $stable(dac_code));

  assert_therm_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(seg_on) == int'(dac_code[RES_W-1:BIN_W]));

  assert_therm_shape_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((32'(seg_on) + 32'd1) & 32'(seg_on)) == 32'd0);

  assert_bin_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bin_on == dac_code[BIN_W-1:0]);
endmodule

bind dac_front dac_front_chk #(.BUS_W(BUS_W), .RES_W(RES_W), .SEG_BITS(SEG_BITS)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_n     (cs_n),
  .wr_n     (wr_n),
  .addr     (addr),
  .data     (data),
  .dac_code (dac_code),
  .seg_on   (seg_on),
  .bin_on   (bin_on)
);

// File: tb/dac_front_tb.sv
module dac_front_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        cs_n;
  logic        wr_n;
  logic [1:0]  addr;
  logic [7:0]  data;
  logic [13:0] dac_code;
  logic [6:0]  seg_on;
  logic [10:0] bin_on;

  int checks;
  int errors;
  bit done;

  logic [5:0]  m_hi;
  logic [7:0]  m_lo;
  logic [13:0] m_dac;

  dac_front dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .addr(addr),
    .data(data), .dac_code(dac_code), .seg_on(seg_on), .bin_on(bin_on)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [6:0] exp_seg(input logic [13:0] c);
    logic [6:0] s = '0;
    for (int i = 0; i < 7; i++) if (int'(c[13:11]) > i) s[i] = 1'b1;
    return s;
  endfunction

  task automatic check_out(input string tag, input logic [13:0] exp);
    checks++;
    if (dac_code !== exp || seg_on !== exp_seg(exp) || bin_on !== exp[10:0]) begin
      errors++;
      $display("FAIL %s dac=%h seg=%h bin=%h expected dac=%h seg=%h bin=%h",
               tag, dac_code, seg_on, bin_on, exp, exp_seg(exp), exp[10:0]);
    end
  endtask

  task automatic model_write(input logic [1:0] a, input logic [7:0] d);
    case (a)
      2'b00: begin m_hi = d[5:0]; m_lo = d; m_dac = {d[5:0], d}; end
      2'b01: m_hi = d[5:0];
      2'b10: m_lo = d;
      default: m_dac = {m_hi, m_lo};
    endcase
  endtask

  task automatic bus_op(input logic sel_n, input logic [1:0] a, input logic [7:0] d,
                        input int hold);
    @(negedge clk);
    cs_n = sel_n; wr_n = 1'b0; addr = a; data = d;
    repeat (hold) @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
    if (!sel_n) model_write(a, d);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 0;
    cs_n = 1'b1; wr_n = 1'b1; addr = 2'b00; data = 8'h00; rst_n = 1'b0;
    m_hi = '0; m_lo = '0; m_dac = '0;
    void'($urandom(32'h0DAC_5EED));

    // R1: scribble while in reset, state must stay zero
    @(negedge clk); cs_n = 1'b0; wr_n = 1'b0; data = 8'hFF;
    @(negedge clk); cs_n = 1'b1; wr_n = 1'b1;
    repeat (2) @(negedge clk);
    check_out("R1 in reset", 14'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    check_out("R1 after release", 14'h0000);

    // R4: direct load to full scale and back to zero
    bus_op(1'b0, 2'b00, 8'hFF, 1); check_out("R4 direct full scale", 14'h3FFF);
    bus_op(1'b0, 2'b00, 8'h00, 1); check_out("R4 direct zero", 14'h0000);

    // R8: all eight thermometer codes via direct load of k<<3
    for (int k = 0; k < 8; k++) begin
      bus_op(1'b0, 2'b00, 8'(k << 3), 1);
      check_out($sformatf("R8 segment code %0d", k), m_dac);
    end

    // R5 R6 R7: high then low then transfer
    bus_op(1'b0, 2'b00, 8'h00, 1);
    bus_op(1'b0, 2'b01, 8'h2A, 1); check_out("R5 high byte no dac change", 14'h0000);
    bus_op(1'b0, 2'b10, 8'h5C, 1); check_out("R6 low byte no dac change", 14'h0000);
    bus_op(1'b0, 2'b11, 8'hFF, 1); check_out("R7 transfer hi then lo", 14'h2A5C);
    // R6 R5 R7: reverse order, transfer data ignored
    bus_op(1'b0, 2'b10, 8'h81, 1); check_out("R6 low byte hold", 14'h2A5C);
    bus_op(1'b0, 2'b01, 8'h13, 1); check_out("R5 high byte hold", 14'h2A5C);
    bus_op(1'b0, 2'b11, 8'h00, 1); check_out("R7 transfer lo then hi", 14'h1381);
    // R7: repeated transfer with other bus data leaves registers as they were
    bus_op(1'b0, 2'b11, 8'hA5, 1); check_out("R7 data ignored", 14'h1381);

    // R10: upper bits of the high byte dropped
    bus_op(1'b0, 2'b01, 8'hC5, 1);
    bus_op(1'b0, 2'b10, 8'h00, 1);
    bus_op(1'b0, 2'b11, 8'h00, 1); check_out("R10 high byte upper bits", 14'h0500);

    // R2: strobes while deselected, for every address code
    for (int a = 0; a < 4; a++) begin
      bus_op(1'b1, 2'(a), 8'hEE, 2);
      check_out($sformatf("R2 deselected addr %0d", a), 14'h0500);
    end
    // R2: select toggles with write high
    @(negedge clk); wr_n = 1'b1; cs_n = 1'b0; addr = 2'b00; data = 8'h77;
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk); check_out("R2 select without strobe", 14'h0500);

    // R3: long strobe with data changing mid-strobe makes one update
    @(negedge clk); cs_n = 1'b0; wr_n = 1'b0; addr = 2'b00; data = 8'h11;
    @(negedge clk); data = 8'h22;
    @(negedge clk); check_out("R3 held strobe single update", 14'h1111);
    @(negedge clk); cs_n = 1'b1; wr_n = 1'b1;
    @(negedge clk); check_out("R3 after held strobe", 14'h1111);
    m_hi = 6'h11; m_lo = 8'h11; m_dac = 14'h1111;

    // Random mix: R4 R5 R6 R7 R8 R9 R2
    for (int n = 0; n < 400; n++) begin
      logic       sel_n;
      logic [1:0] a;
      logic [7:0] d;
      int         h;
      sel_n = (($urandom % 5) == 0);
      a     = 2'($urandom % 4);
      d     = 8'($urandom);
      h     = 1 + int'($urandom % 3);
      bus_op(sel_n, a, d, h);
      check_out($sformatf("R9 random op %0d addr %0d", n, a), m_dac);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule